// File: doc/BRIEF.md
# Chainable Up-Counting Timer with Slave Control

A 16-bit up-counting timer. A programmable prescaler divides the system clock, and the counter advances once per divided tick. When it reaches the reload limit it wraps to zero and raises a one-cycle update event. A single compare channel produces a PWM-style reference level. Software drives the block through a synchronous write port with a combinational read-back. Through that port it can start and stop counting, force a reinitialisation, choose the master and slave behaviour, and load the counter directly.

Any timer can act as a master by putting one of several internal conditions on its trigger output. It can also act as a slave by picking one of its internal trigger lines, which is then synchronised. In gated mode the selected line allows or blocks counting. In trigger mode a rising edge on that line sets the enable bit by hardware. Two instances can be chained: the master's update pulse starts the slave, and the slave counts on from whatever value software preloaded.

Register addresses: 0 control, 1 event, 2 counter, 3 prescaler, 4 reload, 5 compare. The control word packs the enable bit in bit 0, the master select in bits 3:1, the trigger select in bits 6:4 and the slave select in bits 9:7.

Top module: `sync_timer`

## Requirements
- R1: After reset the counter, the prescaler count, the control word and the compare value are 0, the reload value is all ones, and both trig_o and oc_ref_o are low.
- R2: With prescaler value P and counting enabled, the counter advances once every P+1 clocks. The first step comes P+1 clocks after the enabling write, provided the prescaler count was zero.
- R3: When the counter is at or above the reload value and a prescaled tick occurs, the counter becomes 0. In the same clock a one-clock update event is registered.
- R4: Writing 1 to bit 0 of the event register (address 1) clears the counter and the prescaler count in that clock. This takes priority over every other counter action, and the enable bit is left unchanged.
- R5: A write to the counter register (address 2) loads the written value. Counting then continues from that value.
- R6: Slave select 101 (gated): the counter advances only while the synchronised selected trigger is high. It keeps its value while that trigger is low.
- R7: Slave select 110 (trigger): a rising edge on the selected trigger sets the enable bit two clocks after the edge is first sampled. A line held high starts the timer only once.
- R8: Trigger select value n picks internal trigger line n, so 000 selects line 0. Values above the number of lines select a constant low.
- R9: Master select 100 drives trig_o with the compare reference. oc_ref_o is high while the counter is below the compare value and low otherwise.
- R10: Master select 000 gives a one-clock trig_o pulse in the clock after a software update write. Master select 001 makes trig_o follow the enable bit. Master select 010 pulses trig_o for one clock on each update event.
- R11: When a master's update pulse feeds a slave in trigger mode, the slave starts counting from its preloaded nonzero counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| trig_i | input | 4 | Internal trigger lines from other timers |
| trig_o | output | 1 | Master trigger output |
| oc_ref_o | output | 1 | Channel-1 compare reference |

## Verification
The hardest case to reach is a slave started in trigger mode by a real master. It needs two instances wired together. The master's software-update pulse must not start the slave while the pair is being set up, and the exact cycle of the slave's first count depends on the master's wrap, the slave's two synchronising flops and its enable register. The bench therefore programs the master completely while the slave's slave mode is still off, and only then arms the slave with a preload of 0xE7. It then checks that the slave is idle, enabled and counting at fixed clock offsets from the master's enabling write. Re-arming the slave while its trigger line stays high is forced in a separate scenario: the bench clears the enable bit with the line held high.

// File: rtl/sync_timer_pkg.sv
package sync_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int MODE_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd5;

  localparam logic [MODE_W-1:0] MMS_SWUPD = 3'b000;
  localparam logic [MODE_W-1:0] MMS_CEN   = 3'b001;
  localparam logic [MODE_W-1:0] MMS_UPD   = 3'b010;
  localparam logic [MODE_W-1:0] MMS_REF   = 3'b100;

  localparam logic [MODE_W-1:0] SMS_OFF   = 3'b000;
  localparam logic [MODE_W-1:0] SMS_GATED = 3'b101;
  localparam logic [MODE_W-1:0] SMS_TRIG  = 3'b110;

  typedef struct packed {
    logic [MODE_W-1:0] sms;
    logic [MODE_W-1:0] tsel;
    logic [MODE_W-1:0] mms;
    logic              cen;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sync_timer_regs.sv
module sync_timer_regs
  import sync_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              cen_set_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  arr_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              ug_o,
  output logic              cnt_we_o,
  output logic [CNT_W-1:0]  rdata_o
);
  ctrl_t             ctrl_q;
  logic [PSC_W-1:0]  psc_q;
  logic [CNT_W-1:0]  arr_q, cmp_q;
  logic              ctrl_we;

  assign ctrl_we  = we_i && (addr_i == A_CTRL);
  assign ug_o     = we_i && (addr_i == A_EVT) && wdata_i[0];
  assign cnt_we_o = we_i && (addr_i == A_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      arr_q  <= '1;
      cmp_q  <= '0;
    end else begin
      if (ctrl_we)        ctrl_q     <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (cen_set_i) ctrl_q.cen <= 1'b1;
      if (we_i && addr_i == A_PSC) psc_q <= wdata_i[PSC_W-1:0];
      if (we_i && addr_i == A_ARR) arr_q <= wdata_i;
      if (we_i && addr_i == A_CMP) cmp_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = CNT_W'(ctrl_q);
      A_CNT:   rdata_o = cnt_i;
      A_PSC:   rdata_o = CNT_W'(psc_q);
      A_ARR:   rdata_o = arr_q;
      A_CMP:   rdata_o = cmp_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign psc_o  = psc_q;
  assign arr_o  = arr_q;
  assign cmp_o  = cmp_q;

  // R7: hardware start wins only when no control write collides
  a_r7_cen_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_set_i && !ctrl_we) |=> ctrl_o.cen);
endmodule

// File: rtl/sync_timer_slave.sv
module sync_timer_slave
  import sync_timer_pkg::*;
#(
  parameter int NUM_TRIG = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [MODE_W-1:0]   tsel_i,
  input  logic [MODE_W-1:0]   sms_i,
  output logic                gate_o,
  output logic                cen_set_o
);
  localparam int SEL_N = 2 ** MODE_W;

  logic [SEL_N-1:0] trig_pad;
  logic             sel, sync1_q, sync2_q, rise;

  assign trig_pad = SEL_N'(trig_i);
  assign sel      = trig_pad[tsel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= sel;
      sync2_q <= sync1_q;
    end
  end

  assign rise      = sync1_q && !sync2_q;
  assign gate_o    = (sms_i == SMS_GATED) ? sync1_q : 1'b1;
  assign cen_set_o = (sms_i == SMS_TRIG) && rise;

  // R7: a level held high cannot produce back-to-back starts
  a_r7_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_set_o |=> !cen_set_o);
endmodule

// File: rtl/sync_timer_core.sv
module sync_timer_core #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ug_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uev_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_cnt_q;
  logic             tick, wrap, uev_q;

  assign tick = run_i && (psc_cnt_q >= psc_i);
  assign wrap = tick && !cnt_we_i && (cnt_q >= arr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      psc_cnt_q <= '0;
      uev_q     <= 1'b0;
    end else begin
      uev_q <= ug_i || wrap;
      if (ug_i) begin
        cnt_q     <= '0;
        psc_cnt_q <= '0;
      end else begin
        if (run_i) psc_cnt_q <= tick ? '0 : psc_cnt_q + PSC_W'(1);
        if (cnt_we_i)  cnt_q <= cnt_wdata_i;
        else if (wrap) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign uev_o = uev_q;

  a_r4_ug_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_o == '0));
  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && !ug_i) |=> (cnt_o == $past(cnt_wdata_i)));
  a_r3_wrap_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ug_i && !cnt_we_i && cnt_o >= arr_i) |=> (cnt_o == '0 && uev_o));
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ug_i && !cnt_we_i) |=> $stable(cnt_o));
endmodule

// File: rtl/sync_timer.sv
module sync_timer
  import sync_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 16,
  parameter int NUM_TRIG = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2:0]          addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    rdata_o,
  input  logic [NUM_TRIG-1:0] trig_i,
  output logic                trig_o,
  output logic                oc_ref_o
);
  ctrl_t            ctrl;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] arr, cmp, cnt;
  logic             ug, ug_q, cnt_we, cen_set, gate, uev;

  sync_timer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cen_set_i(cen_set), .cnt_i(cnt), .ctrl_o(ctrl), .psc_o(psc),
    .arr_o(arr), .cmp_o(cmp), .ug_o(ug), .cnt_we_o(cnt_we), .rdata_o
  );

  sync_timer_slave #(.NUM_TRIG(NUM_TRIG)) u_slave (
    .clk_i, .rst_ni, .trig_i, .tsel_i(ctrl.tsel), .sms_i(ctrl.sms),
    .gate_o(gate), .cen_set_o(cen_set)
  );

  sync_timer_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk_i, .rst_ni, .run_i(ctrl.cen && gate), .ug_i(ug),
    .cnt_we_i(cnt_we), .cnt_wdata_i(wdata_i), .psc_i(psc), .arr_i(arr),
    .cnt_o(cnt), .uev_o(uev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ug_q <= 1'b0;
    else         ug_q <= ug;
  end

  assign oc_ref_o = (cnt < cmp);

  always_comb begin
    unique case (ctrl.mms)
      MMS_SWUPD: trig_o = ug_q;
      MMS_CEN:   trig_o = ctrl.cen;
      MMS_UPD:   trig_o = uev;
      MMS_REF:   trig_o = oc_ref_o;
      default:   trig_o = 1'b0;
    endcase
  end

  // R10: software update shows on trig_o one clock later
  a_r10_swupd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug && ctrl.mms == MMS_SWUPD) |=> trig_o);
  // R6: closed gate freezes the counter
  a_r6_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.sms == SMS_GATED && !gate && !ug && !cnt_we) |=> $stable(cnt));
endmodule

// File: tb/sync_timer_tb.sv
module sync_timer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_s = 1'b0, we_m = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_s, rdata_m;
  logic [2:0]  tb_trig = '0;
  logic        trig_s, ref_s, trig_m, ref_m;
  logic [3:0]  dut_trig;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign dut_trig = {trig_m, tb_trig};

  sync_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we_s), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_s), .trig_i(dut_trig), .trig_o(trig_s), .oc_ref_o(ref_s)
  );

  sync_timer mst_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we_m), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_m), .trig_i(4'b0000), .trig_o(trig_m), .oc_ref_o(ref_m)
  );

  function automatic logic [15:0] ctl(bit cen, logic [2:0] mms, logic [2:0] tsel, logic [2:0] sms);
    return {6'd0, sms, tsel, mms, cen};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit m, logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (m) we_m = 1'b1; else we_s = 1'b1;
    @(negedge clk);
    we_m = 1'b0; we_s = 1'b0;
  endtask

  task automatic rd(bit m, logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = m ? rdata_m : rdata_s;
  endtask

  // stop, set psc/arr/cmp, clear counter via software update
  task automatic setup(bit m, logic [15:0] psc, logic [15:0] arr, logic [15:0] cmp);
    wr(m, 3'd0, 16'd0);
    wr(m, 3'd3, psc);
    wr(m, 3'd4, arr);
    wr(m, 3'd5, cmp);
    wr(m, 3'd1, 16'd1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, 3'd2, v); chk(v == 0, "R1 cnt", v, 0);
    rd(0, 3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(0, 3'd4, v); chk(v == 16'hFFFF, "R1 arr", v, 16'hFFFF);
    chk(trig_s == 0 && ref_s == 0, "R1 outputs", {trig_s, ref_s}, 0);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    setup(0, 16'd2, 16'hFFFF, 16'd0);
    wr(0, 3'd0, ctl(1, 3'd0, 3'd0, 3'd0));
    step(8); rd(0, 3'd2, v); chk(v == 2, "R2 after 8 clocks", v, 2);
    step(1); rd(0, 3'd2, v); chk(v == 3, "R2 after 9 clocks", v, 3);
  endtask

  task automatic t_wrap_upd();
    logic [15:0] v;
    int first = -1, cnt = 0;
    setup(0, 16'd0, 16'd5, 16'd0);
    wr(0, 3'd0, ctl(1, 3'd2, 3'd0, 3'd0));
    step(5); rd(0, 3'd2, v); chk(v == 5, "R3 at reload", v, 5);
    chk(trig_s == 0, "R10 no pulse before wrap", trig_s, 0);
    step(1); rd(0, 3'd2, v); chk(v == 0, "R3 wrapped", v, 0);
    chk(trig_s == 1, "R3 update pulse", trig_s, 1);
    step(1); chk(trig_s == 0, "R3 pulse one clock", trig_s, 0);
    // update-event master output over two periods (arr=3)
    setup(0, 16'd0, 16'd3, 16'd0);
    wr(0, 3'd0, ctl(1, 3'd2, 3'd0, 3'd0));
    for (int i = 0; i < 10; i++) begin
      #1;
      if (trig_s) begin cnt++; if (first < 0) first = i; end
      step(1);
    end
    chk(cnt == 2, "R10 update pulses", cnt, 2);
    chk(first == 4, "R10 first update pulse", first, 4);
  endtask

  task automatic t_ug();
    logic [15:0] v;
    setup(0, 16'd3, 16'hFFFF, 16'd0);
    wr(0, 3'd0, ctl(1, 3'd0, 3'd0, 3'd0));
    step(10);
    wr(0, 3'd1, 16'd1);
    #1; chk(trig_s == 1, "R10 swupd pulse", trig_s, 1);
    rd(0, 3'd2, v); chk(v == 0, "R4 cleared", v, 0);
    step(1); chk(trig_s == 0, "R10 swupd one clock", trig_s, 0);
    step(2); rd(0, 3'd2, v); chk(v == 0, "R4 prescaler cleared", v, 0);
    step(1); rd(0, 3'd2, v); chk(v == 1, "R4 first step", v, 1);
    rd(0, 3'd0, v); chk(v[0] == 1, "R4 enable kept", v[0], 1);
  endtask

  task automatic t_load();
    logic [15:0] v;
    setup(0, 16'd0, 16'hFFFF, 16'd0);
    wr(0, 3'd2, 16'h00E7);
    rd(0, 3'd2, v); chk(v == 16'h00E7, "R5 load", v, 16'h00E7);
    wr(0, 3'd0, ctl(1, 3'd0, 3'd0, 3'd0));
    step(4); rd(0, 3'd2, v); chk(v == 16'h00EB, "R5 resume", v, 16'h00EB);
  endtask

  task automatic t_gated();
    logic [15:0] v;
    setup(0, 16'd0, 16'hFFFF, 16'd0);
    wr(0, 3'd0, ctl(1, 3'd0, 3'd0, 3'd5));
    step(4); rd(0, 3'd2, v); chk(v == 0, "R6 held while low", v, 0);
    tb_trig[0] = 1'b1; step(7); tb_trig[0] = 1'b0;
    step(4); rd(0, 3'd2, v); chk(v == 7, "R6 counted high clocks", v, 7);
    step(5); rd(0, 3'd2, v); chk(v == 7, "R6 held after low", v, 7);
  endtask

  task automatic t_select();
    logic [15:0] v;
    setup(0, 16'd0, 16'hFFFF, 16'd0);
    wr(0, 3'd0, ctl(1, 3'd0, 3'd1, 3'd5));
    tb_trig[0] = 1'b1; step(5); tb_trig[0] = 1'b0;
    step(3); rd(0, 3'd2, v); chk(v == 0, "R8 line 0 ignored", v, 0);
    tb_trig[1] = 1'b1; step(3); tb_trig[1] = 1'b0;
    step(3); rd(0, 3'd2, v); chk(v == 3, "R8 line 1 selected", v, 3);
    wr(0, 3'd0, ctl(1, 3'd0, 3'd6, 3'd5));
    tb_trig = 3'b111; step(4); tb_trig = '0;
    step(3); rd(0, 3'd2, v); chk(v == 3, "R8 missing line low", v, 3);
  endtask

  task automatic t_trigger();
    logic [15:0] v, held;
    setup(0, 16'd0, 16'hFFFF, 16'd0);
    wr(0, 3'd2, 16'h0020);
    wr(0, 3'd0, ctl(0, 3'd0, 3'd0, 3'd6));
    tb_trig[0] = 1'b1;
    step(1); rd(0, 3'd0, v); chk(v[0] == 0, "R7 not yet enabled", v[0], 0);
    step(1); rd(0, 3'd0, v); chk(v[0] == 1, "R7 enable set", v[0], 1);
    rd(0, 3'd2, v); chk(v == 16'h0020, "R7 start value", v, 16'h0020);
    step(3); rd(0, 3'd2, v); chk(v == 16'h0023, "R7 counting", v, 16'h0023);
    wr(0, 3'd0, ctl(0, 3'd0, 3'd0, 3'd6));
    rd(0, 3'd2, held);
    step(5); rd(0, 3'd0, v); chk(v[0] == 0, "R7 held level no restart", v[0], 0);
    rd(0, 3'd2, v); chk(v == held, "R7 counter frozen", v, held);
    tb_trig[0] = 1'b0; step(3);
    tb_trig[0] = 1'b1; step(3);
    rd(0, 3'd0, v); chk(v[0] == 1, "R7 new edge restarts", v[0], 1);
    tb_trig[0] = 1'b0;
  endtask

  task automatic t_ref();
    logic [15:0] v;
    int bad = 0;
    setup(0, 16'd0, 16'd3, 16'd2);
    wr(0, 3'd0, ctl(1, 3'd4, 3'd0, 3'd0));
    for (int i = 0; i < 8; i++) begin
      #1;
      if (ref_s !== ((i % 4) < 2) || trig_s !== ref_s) bad++;
      step(1);
    end
    chk(bad == 0, "R9 reference waveform", bad, 0);
    wr(0, 3'd0, ctl(1, 3'd1, 3'd0, 3'd0));
    #1; chk(trig_s == 1, "R10 mirrors enable on", trig_s, 1);
    wr(0, 3'd0, ctl(0, 3'd1, 3'd0, 3'd0));
    #1; chk(trig_s == 0, "R10 mirrors enable off", trig_s, 0);
  endtask

  task automatic t_chain();
    logic [15:0] v;
    wr(0, 3'd0, 16'd0);
    setup(1, 16'd0, 16'd3, 16'd0);
    wr(1, 3'd0, ctl(0, 3'd2, 3'd0, 3'd0));
    setup(0, 16'd0, 16'hFFFF, 16'd0);
    wr(0, 3'd2, 16'h00E7);
    wr(0, 3'd0, ctl(0, 3'd0, 3'd3, 3'd6));
    step(5);
    rd(0, 3'd0, v); chk(v[0] == 0, "R11 slave idle", v[0], 0);
    rd(0, 3'd2, v); chk(v == 16'h00E7, "R11 preload kept", v, 16'h00E7);
    wr(1, 3'd0, ctl(1, 3'd2, 3'd0, 3'd0));
    step(6);
    rd(0, 3'd0, v); chk(v[0] == 1, "R11 slave started", v[0], 1);
    rd(0, 3'd2, v); chk(v == 16'h00E7, "R11 start value", v, 16'h00E7);
    step(3); rd(0, 3'd2, v); chk(v == 16'h00EA, "R11 slave counting", v, 16'h00EA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_prescale();
    t_wrap_upd();
    t_ug();
    t_load();
    t_gated();
    t_select();
    t_trigger();
    t_ref();
    t_chain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule